// File: doc/BRIEF.md
# Serial PROM Programming-Mode Controller

This block is the device-side controller that lets an external programmer write a one-time-programmable serial memory one bit per clock. Nothing is written until a supply-level handshake on the programming rail is seen. The rail is modelled as a 2-bit level: `00` normal, `01` access level, `10` high programming level, and `11` treated as normal. The handshake needs the two select pins, `ce` and `oe`, held high. Once the block is in programming mode, every rising clock edge does one job, chosen by the `ce`/`oe` pair:

- shift one bit into a word latch,
- shift one bit of the addressed word out for verification,
- advance the word address.

An edge with the rail at the high level commits the latch into the addressed word. The commit is a bitwise AND, because a programmed bit can only go from 1 to 0. The array has `DEPTH` data words plus one extra word above them. That extra word holds the reset polarity: all zeros means active-low, anything else means active-high. The polarity is reported on `ceo`. It has no effect on how `ce`/`oe` are decoded while programming.

The serial pins carry one bit per edge with no back-pressure. The programmer owns the clock and decides which edges happen, so the only flow control is whether an edge occurs at all. Array contents reset to all ones (blank).

Top module: `sprog_ctrl`

## Requirements
- R1: After reset the block is out of programming mode (`prog_mode`=0), `dout_en`=0 and `ceo_en`=0, and every word, including the polarity word, reads as all ones.
- R2: Programming mode is entered on the edge that follows this sequence, all with `ce`=`oe`=1: at least two consecutive rail-high (`10`) edges, then one access-level (`01`) edge. Extra high edges before the access edge keep the sequence armed.
- R3: During the entry sequence, an edge with `ce` or `oe` low, or with the rail at any level other than the one expected next, returns the sequence to idle.
- R4: Outside programming mode, no activity on `ce`, `oe`, `din` or the rail changes any array word.
- R5: In mode, with the rail not high, an edge with `ce`=1 and `oe`=1 shifts `din` into the latch LSB and moves the older bits up one place. A word is therefore loaded MSB first in 32 edges.
- R6: In mode, with the rail not high, `ce`=0 and `oe`=1 raise `dout_en` and present bit (W-1-k) of the addressed word on `dout`, where k is the number of readout edges since the last non-readout edge. Any edge with `ce`=0 clears the latch to all ones.
- R7: In mode, with the rail not high, an edge with `ce`=1 and `oe`=0 advances the address. The address wraps from the polarity word (address DEPTH) back to 0, and readout restarts at the MSB.
- R8: An in-mode edge with the rail high writes (addressed word AND latch) into the array. That edge neither shifts the latch nor moves the address.
- R9: `ceo_en` is 1 only in mode with the rail not high. `ceo` is 0 when the polarity word is all zeros and 1 otherwise, and the stored polarity does not change the `ce`/`oe` decode.
- R10: An in-mode edge with `ce`=0 and `oe`=0 leaves programming mode. The next entry starts again at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| vpp_lvl | input | 2 | Programming rail level: 00 normal, 01 access, 10 high, 11 normal |
| ce | input | 1 | Select pin, decoded with `oe` |
| oe | input | 1 | Select pin, decoded with `ce` |
| din | input | 1 | Serial data into the word latch |
| dout | output | 1 | Serial data from the addressed word (0 when not enabled) |
| dout_en | output | 1 | Output-driver enable for `dout` |
| ceo | output | 1 | Stored reset polarity (1 active-high, 0 active-low) |
| ceo_en | output | 1 | Output-driver enable for `ceo`; low models high impedance |
| prog_mode | output | 1 | Programming mode is active |

## Verification
The commit strobe and the shift-in decode can fall on the same edge. This happens when the rail is raised while `ce` and `oe` are both still high, which is exactly how a programmer pulses a latched word into the array. The bench provokes it every time it programs a word: it holds `din` at 0 on the strobe edge and then reads the word back serially. A readback that equals the AND of the old contents with the loaded pattern, rather than a pattern shifted by one place, shows that the strobe took priority. The same edge is also checked for `ceo_en` going low.

// File: rtl/sprog_pkg.sv
package sprog_pkg;

  typedef enum logic [1:0] {
    VPP_NORM = 2'b00,
    VPP_ACC  = 2'b01,
    VPP_HIGH = 2'b10,
    VPP_RSV  = 2'b11
  } vpp_lvl_e;

  typedef enum logic [1:0] {
    ENT_IDLE  = 2'b00,
    ENT_HI1   = 2'b01,
    ENT_ARMED = 2'b10,
    ENT_MODE  = 2'b11
  } entry_st_e;

endpackage

// File: rtl/sprog_entry.sv
module sprog_entry
  import sprog_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ce,
  input  logic     oe,
  input  vpp_lvl_e vpp,
  output logic     prog_mode
);

  entry_st_e st_q, st_d;
  logic      held, is_hi, is_acc;

  always_comb begin
    held   = ce & oe;
    is_hi  = (vpp == VPP_HIGH);
    is_acc = (vpp == VPP_ACC);
    st_d   = st_q;
    unique case (st_q)
      ENT_IDLE:  st_d = (held && is_hi) ? ENT_HI1 : ENT_IDLE;
      ENT_HI1:   st_d = (held && is_hi) ? ENT_ARMED : ENT_IDLE;
      ENT_ARMED: begin
        if (!held)      st_d = ENT_IDLE;
        else if (is_hi) st_d = ENT_ARMED;
        else if (is_acc) st_d = ENT_MODE;
        else            st_d = ENT_IDLE;
      end
      ENT_MODE:  st_d = (!ce && !oe) ? ENT_IDLE : ENT_MODE;
      default:   st_d = ENT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ENT_IDLE;
    else        st_q <= st_d;
  end

  assign prog_mode = (st_q == ENT_MODE);

  // R2: mode can only begin right after an access-level edge with both selects high
  a_r2_entry_on_access: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_mode) |-> $past(vpp == VPP_ACC && ce && oe));

  // R3: a normal-level edge outside the mode never enters it
  a_r3_normal_blocks_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_mode && vpp == VPP_NORM) |=> !prog_mode);

  // R10: both selects low leave the mode
  a_r10_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_mode && !ce && !oe) |=> !prog_mode);

endmodule

// File: rtl/sprog_latch.sv
module sprog_latch #(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode,
  input  logic                 strobe,
  input  logic                 ce,
  input  logic                 oe,
  input  logic                 din,
  output logic [W-1:0]         latch_q,
  output logic [$clog2(W)-1:0] optr
);

  localparam int PW = $clog2(W);
  localparam logic [PW-1:0] LAST_BIT = PW'(W - 1);

  logic reading;
  assign reading = mode & ~strobe & ~ce & oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      optr    <= '0;
    end else if (!mode) begin
      latch_q <= '1;
      optr    <= '0;
    end else begin
      if (!strobe) begin
        if (!ce)     latch_q <= '1;
        else if (oe) latch_q <= {latch_q[W-2:0], din};
      end
      if (reading) optr <= (optr == LAST_BIT) ? '0 : optr + PW'(1);
      else         optr <= '0;
    end
  end

  // R8: a commit edge leaves the latch untouched while the mode is kept
  a_r8_latch_hold_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && strobe && (ce || oe)) |=> $stable(latch_q));

endmodule

// File: rtl/sprog_array.sv
module sprog_array #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode,
  input  logic         strobe,
  input  logic         incr,
  input  logic [W-1:0] latch_q,
  output logic [W-1:0] rd_word,
  output logic [W-1:0] pol_word
);

  localparam int AW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH);

  logic [W-1:0]  mem [0:DEPTH];
  logic [AW-1:0] addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr <= '0;
    else if (!mode)  addr <= '0;
    else if (incr)   addr <= (addr == LAST_ADDR) ? '0 : addr + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= DEPTH; i++) mem[i] <= '1;
    end else if (mode && strobe && addr <= LAST_ADDR) begin
      mem[addr] <= mem[addr] & latch_q;
    end
  end

  assign rd_word  = (addr <= LAST_ADDR) ? mem[addr] : '1;
  assign pol_word = mem[DEPTH];

  // R8: one-time cells only ever clear bits
  for (genvar g = 0; g <= DEPTH; g++) begin : g_otp
    a_r8_never_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (mem[g] & ~$past(mem[g])) == '0);
  end

  // R4: outside the mode the polarity word cannot change
  a_r4_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |=> $stable(pol_word));

endmodule

// File: rtl/sprog_ctrl.sv
module sprog_ctrl
  import sprog_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] vpp_lvl,
  input  logic       ce,
  input  logic       oe,
  input  logic       din,
  output logic       dout,
  output logic       dout_en,
  output logic       ceo,
  output logic       ceo_en,
  output logic       prog_mode
);

  localparam int PW = $clog2(W);

  vpp_lvl_e      vpp;
  logic          strobe, incr;
  logic [W-1:0]  latch_q, rd_word, pol_word;
  logic [PW-1:0] optr, bit_idx;

  assign vpp = vpp_lvl_e'(vpp_lvl);

  sprog_entry u_entry (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce        (ce),
    .oe        (oe),
    .vpp       (vpp),
    .prog_mode (prog_mode)
  );

  assign strobe = (vpp == VPP_HIGH);
  assign incr   = prog_mode & ~strobe & ce & ~oe;

  sprog_latch #(.W(W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (prog_mode),
    .strobe  (strobe),
    .ce      (ce),
    .oe      (oe),
    .din     (din),
    .latch_q (latch_q),
    .optr    (optr)
  );

  sprog_array #(.W(W), .DEPTH(DEPTH)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (prog_mode),
    .strobe   (strobe),
    .incr     (incr),
    .latch_q  (latch_q),
    .rd_word  (rd_word),
    .pol_word (pol_word)
  );

  assign bit_idx = PW'(W - 1) - optr;
  assign dout_en = prog_mode & ~strobe & ~ce & oe;
  assign dout    = dout_en & rd_word[bit_idx];
  assign ceo_en  = prog_mode & ~strobe;
  assign ceo     = ceo_en & (|pol_word);

endmodule

// File: tb/tb_sprog_ctrl.sv
module tb_sprog_ctrl;

  localparam int W = 32;
  localparam int D = 16;
  localparam logic [1:0] NORM = 2'b00, ACC = 2'b01, HIGH = 2'b10;

  logic clk = 1'b0;
  logic rst_n, ce, oe, din;
  logic [1:0] vpp_lvl;
  logic dout, dout_en, ceo, ceo_en, prog_mode;

  int tests = 0;
  int fails = 0;
  logic [W-1:0] model [0:D];
  int cur_addr = 0;

  always #4 clk = ~clk;

  sprog_ctrl #(.W(W), .DEPTH(D)) dut (
    .clk(clk), .rst_n(rst_n), .vpp_lvl(vpp_lvl), .ce(ce), .oe(oe), .din(din),
    .dout(dout), .dout_en(dout_en), .ceo(ceo), .ceo_en(ceo_en), .prog_mode(prog_mode)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drv(input logic c, input logic o, input logic [1:0] v, input logic d);
    ce = c; oe = o; vpp_lvl = v; din = d;
    #1;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic enter();
    drv(1, 1, HIGH, 0); step(); step();
    drv(1, 1, ACC, 0); step();
    cur_addr = 0;
  endtask

  task automatic load(input logic [W-1:0] w);
    drv(0, 1, ACC, 0); step();
    for (int i = 0; i < W; i++) begin
      drv(1, 1, ACC, w[W-1-i]); step();
    end
  endtask

  task automatic commit(input logic [W-1:0] w);
    drv(1, 1, HIGH, 0);
    chk("R9 ceo_en low while rail high", {31'b0, ceo_en}, 32'd0);
    step();
    model[cur_addr] = model[cur_addr] & w;
  endtask

  task automatic read(output logic [W-1:0] w);
    drv(0, 1, ACC, 0);
    chk("R6 dout_en during readout", {31'b0, dout_en}, 32'd1);
    for (int i = 0; i < W; i++) begin
      w[W-1-i] = dout;
      step();
    end
  endtask

  task automatic incr(input int n);
    drv(1, 0, ACC, 0);
    for (int i = 0; i < n; i++) begin
      step();
      cur_addr = (cur_addr == D) ? 0 : cur_addr + 1;
    end
  endtask

  task automatic t_reset();
    chk("R1 prog_mode after reset", {31'b0, prog_mode}, 32'd0);
    chk("R1 dout_en after reset", {31'b0, dout_en}, 32'd0);
    chk("R1 ceo_en after reset", {31'b0, ceo_en}, 32'd0);
  endtask

  task automatic t_outside();
    drv(1, 1, ACC, 0); repeat (5) step();
    drv(0, 1, HIGH, 0); repeat (2) step();
    drv(1, 0, NORM, 0); step();
    chk("R4 still idle after outside activity", {31'b0, prog_mode}, 32'd0);
    chk("R4 no readout outside mode", {31'b0, dout_en}, 32'd0);
  endtask

  task automatic t_entry_broken();
    drv(1, 1, HIGH, 0); step();
    drv(1, 1, ACC, 0); step();
    chk("R3 one high edge then access", {31'b0, prog_mode}, 32'd0);
    drv(1, 1, HIGH, 0); step(); step();
    drv(0, 1, ACC, 0); step();
    drv(1, 1, ACC, 0); step();
    chk("R3 ce low breaks armed sequence", {31'b0, prog_mode}, 32'd0);
    drv(1, 1, HIGH, 0); step(); step();
    drv(1, 1, NORM, 0); step();
    drv(1, 1, ACC, 0); step();
    chk("R3 normal level breaks armed sequence", {31'b0, prog_mode}, 32'd0);
  endtask

  task automatic t_entry();
    logic [W-1:0] w;
    drv(1, 1, HIGH, 0); step(); step(); step();
    chk("R2 not in mode before access edge", {31'b0, prog_mode}, 32'd0);
    drv(1, 1, ACC, 0); step();
    cur_addr = 0;
    chk("R2 mode after access edge", {31'b0, prog_mode}, 32'd1);
    chk("R9 ceo default active-high", {30'b0, ceo_en, ceo}, 32'd3);
    read(w);
    chk("R4 word0 blank after outside activity", w, model[0]);
  endtask

  task automatic t_program();
    logic [W-1:0] w;
    load(32'hA5C3_0F96); commit(32'hA5C3_0F96); read(w);
    chk("R5 R8 first program of word0", w, model[0]);
    load(32'hFFFF_00FF); commit(32'hFFFF_00FF); read(w);
    chk("R8 second program ANDs into word0", w, 32'hA5C3_0096);
  endtask

  task automatic t_incr();
    logic [W-1:0] w;
    incr(1); read(w);
    chk("R7 word1 blank", w, 32'hFFFF_FFFF);
    load(32'h3C3C_1234); commit(32'h3C3C_1234); read(w);
    chk("R7 word1 programmed", w, model[1]);
    incr(16); read(w);
    chk("R7 address wraps to word0", w, model[0]);
  endtask

  task automatic t_polarity();
    logic [W-1:0] w;
    incr(16);
    load(32'h0000_0000); commit(32'h0000_0000);
    drv(1, 1, ACC, 0);
    chk("R9 ceo reports active-low", {30'b0, ceo_en, ceo}, 32'd2);
    incr(3);
    load(32'h1234_5678); commit(32'h1234_5678); read(w);
    chk("R9 decode unchanged by active-low polarity", w, model[2]);
  endtask

  task automatic t_exit();
    logic [W-1:0] w;
    drv(0, 0, ACC, 0); step();
    chk("R10 mode left on both selects low", {31'b0, prog_mode}, 32'd0);
    drv(0, 1, ACC, 0);
    chk("R10 no readout after exit", {31'b0, dout_en}, 32'd0);
    enter(); read(w);
    chk("R10 re-entry starts at word0", w, model[0]);
    drv(1, 1, ACC, 0); repeat (8) step();
    drv(0, 1, ACC, 0); step();
    commit(32'hFFFF_FFFF); read(w);
    chk("R6 ce low clears partial latch", w, model[0]);
  endtask

  initial begin
    for (int i = 0; i <= D; i++) model[i] = '1;
    rst_n = 1'b0;
    drv(0, 0, NORM, 0);
    repeat (3) step();
    rst_n = 1'b1;
    #1;
    t_reset();
    t_outside();
    t_entry_broken();
    t_entry();
    t_program();
    t_incr();
    t_polarity();
    t_exit();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule